// File: doc/BRIEF.md
# Multiply-Accumulate HI/LO Unit

This block multiplies two 32-bit operands and places the 64-bit outcome in a pair of result registers: the upper word in HI and the lower word in LO. Besides a plain product, it can add the product to the pair or subtract it from the pair, with HI:LO treated as one 64-bit value. Each of these three operations comes in a signed and an unsigned form, which gives six operations in all.

A caller presents two operands and an opcode together with a one-cycle `start` strobe. The product is formed in a registered stage, and the pair is updated on the following edge. A one-cycle `done` pulse marks the update. While an operation is in flight, `busy` is high and further strobes are dropped. For test and for context restore, either register can be loaded directly from a shared data bus while the unit is idle. Both registers can be read at all times on their own output ports.

Top module: `hilo_mac`

## Requirements
- R1: The opcode on `op` selects the operation: bit 0 set means unsigned, and bits 2:1 give the kind (0 plain multiply, 1 multiply-add, 2 multiply-subtract). Codes 0..5 are therefore MUL, MULU, MADD, MADDU, MSUB, MSUBU.
- R2: Bits 63:32 of the 64-bit result are written to HI (`hi`) and bits 31:0 are written to LO (`lo`).
- R3: Signed forms (even codes) sign-extend both operands to 64 bits before multiplying, and keep the low 64 bits of the product.
- R4: Unsigned forms (odd codes) zero-extend both operands to 64 bits before multiplying.
- R5: Multiply-add writes HI:LO + product, modulo 2^64. Plain multiply writes the product alone.
- R6: Multiply-subtract writes HI:LO - product, wrapping modulo 2^64.
- R7: A strobe that is accepted at rising edge k sets `busy` after edge k. At edge k+1, HI/LO are updated, `busy` clears and `done` rises. `done` stays high for exactly one cycle.
- R8: A `start` that is sampled while `busy` is high is ignored. It produces no second `done`, and the result of the earlier operation is unchanged.
- R9: A `start` with a reserved opcode (6 or 7) is ignored. It does not set `busy`, does not pulse `done` and does not change HI/LO.
- R10: While idle, `wr_hi`/`wr_lo` load `wr_data` into HI/LO at the next edge. While `busy` is high they are ignored. With no write and no operation, HI/LO hold their values.
- R11: A synchronous reset clears HI, LO, `busy` and `done` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to run the operation on `op` |
| op | input | 3 | Operation code (R1) |
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| wr_hi | input | 1 | Direct load of HI from `wr_data` |
| wr_lo | input | 1 | Direct load of LO from `wr_data` |
| wr_data | input | 32 | Data for direct loads |
| busy | output | 1 | An operation is in flight |
| done | output | 1 | One-cycle pulse: HI/LO were just updated |
| hi | output | 32 | Current HI register |
| lo | output | 32 | Current LO register |

## Verification
The embedded assertions check the handshake on every cycle. These checks cover the single-cycle `done` pulse, its position two edges after an accepted strobe, the one-cycle `busy` window, the rejection of reserved opcodes, the hold of HI/LO when nothing writes them, and the cleared state after reset. The arithmetic itself can only be shown by the bench's sweep. That sweep runs every operation over a grid of corner operands such as 0x80000000 and 0xFFFFFFFF, with a varying HI:LO starting value, and compares each result with a 64-bit model. The dropped strobe during `busy` and the direct loads that are blocked while busy are also shown by bench scenarios.

// File: rtl/hilo_mac_pkg.sv
package hilo_mac_pkg;

  // Kind of operation, taken from opcode bits 2:1
  typedef enum logic [1:0] {
    KIND_MUL = 2'd0,
    KIND_ADD = 2'd1,
    KIND_SUB = 2'd2,
    KIND_RSV = 2'd3
  } mac_kind_e;

  localparam int unsigned OP_W = 3;

  function automatic logic op_is_legal(input logic [OP_W-1:0] code);
    return code[2:1] != 2'b11;
  endfunction

  function automatic logic op_is_unsigned(input logic [OP_W-1:0] code);
    return code[0];
  endfunction

endpackage

// File: rtl/hilo_mac_mul.sv
module hilo_mac_mul #(
  parameter int unsigned W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           uns,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] prod_q
);
  localparam int unsigned PW = 2 * W;

  // Widen one operand to the product width, by sign or by zero
  function automatic logic [PW-1:0] widen(input logic [W-1:0] x, input logic zero_ext);
    logic fill;
    fill = zero_ext ? 1'b0 : x[W-1];
    return {{W{fill}}, x};
  endfunction

  // Product truncated to PW bits: equal to the signed product modulo 2^PW
  function automatic logic [PW-1:0] mul_wide(input logic [PW-1:0] x, input logic [PW-1:0] y);
    return x * y;
  endfunction

  logic [PW-1:0] prod_d;
  assign prod_d = mul_wide(widen(a, uns), widen(b, uns));

  always_ff @(posedge clk) begin
    if (rst)       prod_q <= '0;
    else if (load) prod_q <= prod_d;
  end

endmodule

// File: rtl/hilo_mac_acc.sv
module hilo_mac_acc
  import hilo_mac_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  mac_kind_e      kind,
  input  logic [2*W-1:0] pair,
  input  logic [2*W-1:0] prod,
  output logic [2*W-1:0] result
);
  localparam int unsigned PW = 2 * W;

  function automatic logic [PW-1:0] combine(input mac_kind_e k,
                                            input logic [PW-1:0] acc,
                                            input logic [PW-1:0] p);
    logic [PW-1:0] r;
    case (k)
      KIND_ADD: r = acc + p;
      KIND_SUB: r = acc - p;
      default:  r = p;
    endcase
    return r;
  endfunction

  assign result = combine(kind, pair, prod);

endmodule

// File: rtl/hilo_mac.sv
module hilo_mac
  import hilo_mac_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [2:0]    op,
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  logic          wr_hi,
  input  logic          wr_lo,
  input  logic [W-1:0]  wr_data,
  output logic          busy,
  output logic          done,
  output logic [W-1:0]  hi,
  output logic [W-1:0]  lo
);
  localparam int unsigned PW = 2 * W;

  logic            busy_q, done_q;
  mac_kind_e       kind_q;
  logic [W-1:0]    hi_q, lo_q;
  logic [PW-1:0]   prod_q, next_pair;

  // Named events for the checks below
  logic op_ok, accept_evt, finish_evt, direct_evt;
  assign op_ok      = op_is_legal(op);
  assign accept_evt = start && !busy_q && op_ok;
  assign finish_evt = busy_q;
  assign direct_evt = (wr_hi || wr_lo) && !busy_q;

  hilo_mac_mul #(.W(W)) u_mul (
    .clk    (clk),
    .rst    (rst),
    .load   (accept_evt),
    .uns    (op_is_unsigned(op)),
    .a      (a),
    .b      (b),
    .prod_q (prod_q)
  );

  hilo_mac_acc #(.W(W)) u_acc (
    .kind   (kind_q),
    .pair   ({hi_q, lo_q}),
    .prod   (prod_q),
    .result (next_pair)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      kind_q <= KIND_MUL;
      hi_q   <= '0;
      lo_q   <= '0;
    end else begin
      busy_q <= accept_evt;
      done_q <= finish_evt;
      if (accept_evt) kind_q <= mac_kind_e'(op[2:1]);
      if (finish_evt) begin
        hi_q <= next_pair[PW-1:W];
        lo_q <= next_pair[W-1:0];
      end else begin
        if (wr_hi) hi_q <= wr_data;
        if (wr_lo) lo_q <= wr_data;
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign hi   = hi_q;
  assign lo   = lo_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R7
  AST_START_TO_DONE: assert property (@(posedge clk) disable iff (rst) accept_evt |=> (busy && !done) ##1 (done && !busy)); // R7
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (rst) busy |=> !busy); // R8
  AST_RSV_OP_DROPPED: assert property (@(posedge clk) disable iff (rst) (start && !busy && !op_ok) |=> !busy); // R9
  AST_PAIR_HOLDS: assert property (@(posedge clk) disable iff (rst) (!busy && !wr_hi && !wr_lo) |=> $stable({hi, lo})); // R10
  AST_RESET_CLEARS: assert property (@(posedge clk) $past(rst) |-> (hi == '0 && lo == '0 && !busy && !done)); // R11

endmodule

// File: tb/hilo_mac_bench.sv
module hilo_mac_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [31:0] a = '0, b = '0, wr_data = '0;
  logic        wr_hi = 1'b0, wr_lo = 1'b0;
  logic        busy, done;
  logic [31:0] hi, lo;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  hilo_mac u_hilo_mac (
    .clk(clk), .rst(rst), .start(start), .op(op), .a(a), .b(b),
    .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_data(wr_data),
    .busy(busy), .done(done), .hi(hi), .lo(lo)
  );

  logic [31:0] grid [8];
  initial begin
    grid[0] = 32'h0000_0000; grid[1] = 32'h0000_0001;
    grid[2] = 32'h0000_0002; grid[3] = 32'h7FFF_FFFF;
    grid[4] = 32'h8000_0000; grid[5] = 32'hFFFF_FFFF;
    grid[6] = 32'h1234_5678; grid[7] = 32'hDEAD_BEEF;
  end

  // Reference: 64-bit arithmetic on integers (R1, R3..R6)
  function automatic logic [63:0] model(input int code, input logic [31:0] x,
                                        input logic [31:0] y, input logic [63:0] acc);
    longint sx, sy;
    logic [63:0] p;
    if (code % 2 == 1) begin
      p = {32'd0, x} * {32'd0, y};
    end else begin
      sx = longint'($signed(x));
      sy = longint'($signed(y));
      p  = 64'(sx * sy);
    end
    case (code / 2)
      1:       return acc + p;
      2:       return acc - p;
      default: return p;
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_pair(input logic [31:0] h, input logic [31:0] l);
    @(negedge clk); wr_hi = 1'b1; wr_data = h;
    @(negedge clk); wr_hi = 1'b0; wr_lo = 1'b1; wr_data = l;
    @(negedge clk); wr_lo = 1'b0;
  endtask

  // Launch one operation, return pair seen when done should be high
  task automatic run_op(input int code, input logic [31:0] x, input logic [31:0] y,
                        output logic [63:0] pair, output logic dn);
    @(negedge clk); start = 1'b1; op = 3'(code); a = x; b = y;
    @(negedge clk); start = 1'b0;
    @(negedge clk); pair = {hi, lo}; dn = done;
  endtask

  initial begin
    logic [63:0] pair, exp;
    logic dn;
    int errs_sweep;

    repeat (3) @(negedge clk);
    check("R11 reset pair", {hi, lo}, 64'd0);
    check("R11 reset flags", {62'd0, busy, done}, 64'd0);
    rst = 1'b0;

    // R2 R10: direct loads land in the right halves
    load_pair(32'hCAFE_F00D, 32'h0BAD_1DEA);
    check("R10 R2 direct load", {hi, lo}, 64'hCAFE_F00D_0BAD_1DEA);

    // Sweep: all six ops over the operand grid (R1 R3 R4 R5 R6 R2)
    errs_sweep = bad;
    for (int code = 0; code < 6; code++) begin
      for (int i = 0; i < 8; i++) begin
        for (int j = 0; j < 8; j++) begin
          logic [63:0] start_pair;
          start_pair = {grid[(i + 3) % 8] ^ 32'h5A5A_0000, grid[(j + 5) % 8]};
          load_pair(start_pair[63:32], start_pair[31:0]);
          exp = model(code, grid[i], grid[j], start_pair);
          run_op(code, grid[i], grid[j], pair, dn);
          case (code)
            0: check("R1 R3 MUL",   pair, exp);
            1: check("R1 R4 MULU",  pair, exp);
            2: check("R5 R3 MADD",  pair, exp);
            3: check("R5 R4 MADDU", pair, exp);
            4: check("R6 R3 MSUB",  pair, exp);
            default: check("R6 R4 MSUBU", pair, exp);
          endcase
          check("R7 done at update", {63'd0, dn}, 64'd1);
        end
      end
    end
    if (bad == errs_sweep) $display("sweep clean");

    // R6 wrap: 0 - (0xFFFFFFFF*0xFFFFFFFF unsigned)
    load_pair(32'd0, 32'd0);
    run_op(5, 32'hFFFF_FFFF, 32'hFFFF_FFFF, pair, dn);
    check("R6 wrap", pair, 64'h0000_0001_FFFF_FFFF);
    // R3: 0x80000000 squared signed = 2^62
    run_op(0, 32'h8000_0000, 32'h8000_0000, pair, dn);
    check("R3 min squared", pair, 64'h4000_0000_0000_0000);
    // R3: -1 * 1 signed
    run_op(0, 32'hFFFF_FFFF, 32'd1, pair, dn);
    check("R3 minus one", pair, 64'hFFFF_FFFF_FFFF_FFFF);

    // R7: timing detail
    @(negedge clk); start = 1'b1; op = 3'd1; a = 32'd3; b = 32'd5;
    @(negedge clk); start = 1'b0;
    check("R7 busy after accept", {62'd0, busy, done}, 64'd2);
    @(negedge clk);
    check("R7 done pulse", {62'd0, busy, done}, 64'd1);
    check("R7 result", {hi, lo}, 64'd15);
    @(negedge clk);
    check("R7 done one cycle", {63'd0, done}, 64'd0);

    // R8: second start while busy dropped; R10: write while busy dropped
    @(negedge clk); start = 1'b1; op = 3'd1; a = 32'd7; b = 32'd6;
    @(negedge clk); op = 3'd1; a = 32'd100; b = 32'd100; wr_hi = 1'b1; wr_data = 32'h5555_5555;
    @(negedge clk); start = 1'b0; wr_hi = 1'b0;
    check("R8 first result kept", {hi, lo}, 64'd42);
    check("R8 R10 one done", {62'd0, busy, done}, 64'd1);
    @(negedge clk);
    check("R8 no second done", {62'd0, busy, done}, 64'd0);
    check("R8 pair unchanged", {hi, lo}, 64'd42);

    // R9: reserved opcodes ignored
    for (int code = 6; code < 8; code++) begin
      @(negedge clk); start = 1'b1; op = 3'(code); a = 32'd9; b = 32'd9;
      @(negedge clk); start = 1'b0;
      check("R9 no busy", {63'd0, busy}, 64'd0);
      @(negedge clk);
      check("R9 no done", {63'd0, done}, 64'd0);
      check("R9 pair held", {hi, lo}, 64'd42);
    end

    // R11: reset mid-operation
    @(negedge clk); start = 1'b1; op = 3'd0; a = 32'd2; b = 32'd2;
    @(negedge clk); start = 1'b0; rst = 1'b1;
    @(negedge clk);
    check("R11 reset while busy", {hi, lo, 30'd0, busy, done} == 96'd0 ? 64'd0 : 64'd1, 64'd0);
    rst = 1'b0;

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule